// File: doc/BRIEF.md
# Split-View 24-Hour Clock Controller

This block keeps the time of day as BCD hours, minutes and seconds in 24-hour form. A one-second tick from upstream advances the time. It drives a multiplexed display of four 7-segment digits. Because there are only four digits, the display shows either hours with minutes or minutes with seconds. A view button switches between the two. A lit decimal point on the second digit from the left marks the boundary between the two fields.

The time is set with three buttons: set, increment and OK. Each press of set moves the block from running to editing hours, then to editing minutes, then back to running. OK leaves edit mode at once. While a field is edited, its two digits blink and the seconds stay frozen. All buttons arrive already debounced, as single-cycle pulses. A refresh tick of about 1 kHz steps the digit scan. Blink timing is derived from that same tick.

Top module: `tod_split_clock`

## Requirements
- R1: After reset the time is 00:00:00, the block is running, the hours:minutes view is selected and digit 0 (rightmost) is enabled.
- R2: While running, each sec_tick_i advances the seconds. Seconds carry into minutes and minutes carry into hours. 23:59:59 is followed by 00:00:00.
- R3: view_btn_i toggles the view. In the hours:minutes view, digits 3..2 show hours tens/ones and digits 1..0 show minutes tens/ones. In the minutes:seconds view, digits 3..2 show minutes and digits 1..0 show seconds.
- R4: dp_o is high exactly while digit 2 is enabled. This holds even when that digit is blanked.
- R5: Each set_btn_i press moves the mode run → edit-hours → edit-minutes → run. In either edit mode, ok_btn_i returns to run and takes priority over a set press in the same cycle. In run, ok_btn_i is ignored.
- R6: A set press in run clears the seconds to 00. While in either edit mode, sec_tick_i is ignored and the seconds hold.
- R7: inc_btn_i adds one to the hours in edit-hours (wrapping 23→00) and one to the minutes in edit-minutes (wrapping 59→00, with no carry into the hours). inc_btn_i is ignored in run.
- R8: In an edit mode, the visible digits of the edited field are blank (seg_o = 0) while the blink phase is off. The phase starts on and flips every BLINK_HALF scan ticks. Other digits are never blanked.
- R9: Exactly one bit of dig_en_no is low. The enabled digit index steps 0→1→2→3→0 on each scan_tick_i and holds otherwise.
- R10: seg_o = {g,f,e,d,c,b,a}, active high. The codes for digits 0..9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sec_tick_i | input | 1 | One-second advance pulse |
| scan_tick_i | input | 1 | Display refresh pulse, one digit per pulse |
| view_btn_i | input | 1 | Toggle between the hours:minutes and minutes:seconds views |
| set_btn_i | input | 1 | Enter edit mode or step to the next field |
| inc_btn_i | input | 1 | Add one to the field being edited |
| ok_btn_i | input | 1 | Confirm the setting and return to run |
| seg_o | output | 7 | Segment drive {g,f,e,d,c,b,a}, active high |
| dp_o | output | 1 | Decimal point used as the field separator |
| dig_en_no | output | 4 | Digit enables, active low, bit 0 rightmost |

## Verification
Every input pulse is captured at one clock edge, and its effect appears on the outputs right after that edge. The display is decoded combinationally from registered state, so a time, mode, view or scan change shows up one cycle after the pulse. The bench drives inputs at the falling edge and steps a behavioural model at the rising edge. It compares seg_o, dp_o and dig_en_no against the model at every falling edge, so each result is checked in the first cycle it is due. Directed readouts walk the scan over all four digits and compare the decoded digits with times derived by hand.

// File: rtl/tod_pkg.sv
package tod_pkg;

  typedef enum logic [1:0] {
    MODE_RUN    = 2'd0,
    MODE_EDIT_H = 2'd1,
    MODE_EDIT_M = 2'd2
  } mode_e;

  typedef enum logic {
    VIEW_HM = 1'b0,
    VIEW_MS = 1'b1
  } view_e;

  typedef logic [3:0] bcd_t;

  typedef struct packed {
    bcd_t h_t;
    bcd_t h_o;
    bcd_t m_t;
    bcd_t m_o;
    bcd_t s_t;
    bcd_t s_o;
  } tod_t;

  // {carry, tens, ones}; wraps to 00 after lim_t:lim_o
  function automatic logic [8:0] bcd2_inc(input bcd_t t, input bcd_t o,
                                          input bcd_t lim_t, input bcd_t lim_o);
    if (t == lim_t && o == lim_o) return {1'b1, 4'd0, 4'd0};
    else if (o == 4'd9)           return {1'b0, t + 4'd1, 4'd0};
    else                          return {1'b0, t, o + 4'd1};
  endfunction

  function automatic logic [6:0] seg_encode(input bcd_t d);
    case (d)
      4'd0: return 7'h3F;
      4'd1: return 7'h06;
      4'd2: return 7'h5B;
      4'd3: return 7'h4F;
      4'd4: return 7'h66;
      4'd5: return 7'h6D;
      4'd6: return 7'h7D;
      4'd7: return 7'h07;
      4'd8: return 7'h7F;
      4'd9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

endpackage

// File: rtl/tod_mode_fsm.sv
module tod_mode_fsm
  import tod_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  set_i,
  input  logic  ok_i,
  input  logic  view_btn_i,
  output mode_e mode_o,
  output view_e view_o,
  output logic  enter_edit_o
);

  mode_e mode_q, mode_d;
  view_e view_q;

  always_comb begin
    mode_d = mode_q;
    if (mode_q != MODE_RUN && ok_i) begin
      mode_d = MODE_RUN;
    end else if (set_i) begin
      case (mode_q)
        MODE_RUN:    mode_d = MODE_EDIT_H;
        MODE_EDIT_H: mode_d = MODE_EDIT_M;
        default:     mode_d = MODE_RUN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_RUN;
      view_q <= VIEW_HM;
    end else begin
      mode_q <= mode_d;
      if (view_btn_i) view_q <= (view_q == VIEW_HM) ? VIEW_MS : VIEW_HM;
    end
  end

  assign mode_o       = mode_q;
  assign view_o       = view_q;
  assign enter_edit_o = (mode_q == MODE_RUN) && set_i;

endmodule

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sec_tick_i,
  input  logic  clr_sec_i,
  input  logic  inc_i,
  input  mode_e mode_i,
  output tod_t  tod_o
);

  tod_t tod_q;
  logic [8:0] s_nx, m_nx, h_nx;

  always_comb begin
    s_nx = bcd2_inc(tod_q.s_t, tod_q.s_o, 4'd5, 4'd9);
    m_nx = bcd2_inc(tod_q.m_t, tod_q.m_o, 4'd5, 4'd9);
    h_nx = bcd2_inc(tod_q.h_t, tod_q.h_o, 4'd2, 4'd3);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tod_q <= '0;
    end else if (clr_sec_i) begin
      tod_q.s_t <= '0;
      tod_q.s_o <= '0;
    end else begin
      case (mode_i)
        MODE_RUN: if (sec_tick_i) begin
          {tod_q.s_t, tod_q.s_o} <= s_nx[7:0];
          if (s_nx[8]) begin
            {tod_q.m_t, tod_q.m_o} <= m_nx[7:0];
            if (m_nx[8]) {tod_q.h_t, tod_q.h_o} <= h_nx[7:0];
          end
        end
        MODE_EDIT_H: if (inc_i) {tod_q.h_t, tod_q.h_o} <= h_nx[7:0];
        MODE_EDIT_M: if (inc_i) {tod_q.m_t, tod_q.m_o} <= m_nx[7:0];
        default: ;
      endcase
    end
  end

  assign tod_o = tod_q;

endmodule

// File: rtl/tod_display.sv
module tod_display
  import tod_pkg::*;
#(
  parameter int unsigned BLINK_HALF = 250
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scan_tick_i,
  input  tod_t       tod_i,
  input  mode_e      mode_i,
  input  view_e      view_i,
  output logic [6:0] seg_o,
  output logic       dp_o,
  output logic [3:0] dig_en_no
);

  localparam int unsigned NDIG    = 4;
  localparam int unsigned IDX_W   = $clog2(NDIG);
  localparam int unsigned BW      = (BLINK_HALF > 1) ? $clog2(BLINK_HALF) : 1;
  localparam int unsigned SEP_POS = 2;

  logic [IDX_W-1:0] idx_q;
  logic [BW-1:0]    bcnt_q;
  logic             blank_ph_q;
  bcd_t             dig [NDIG];
  logic [NDIG-1:0]  blank_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q      <= '0;
      bcnt_q     <= '0;
      blank_ph_q <= 1'b0;
    end else if (scan_tick_i) begin
      idx_q <= idx_q + 1'b1;
      if (bcnt_q == BW'(BLINK_HALF - 1)) begin
        bcnt_q     <= '0;
        blank_ph_q <= ~blank_ph_q;
      end else begin
        bcnt_q <= bcnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    if (view_i == VIEW_HM) begin
      dig[3] = tod_i.h_t; dig[2] = tod_i.h_o;
      dig[1] = tod_i.m_t; dig[0] = tod_i.m_o;
    end else begin
      dig[3] = tod_i.m_t; dig[2] = tod_i.m_o;
      dig[1] = tod_i.s_t; dig[0] = tod_i.s_o;
    end
  end

  // edited field may sit on the upper pair, the lower pair, or be off-screen
  always_comb begin
    blank_mask = '0;
    if (blank_ph_q) begin
      case (mode_i)
        MODE_EDIT_H: if (view_i == VIEW_HM) blank_mask = 4'b1100;
        MODE_EDIT_M: blank_mask = (view_i == VIEW_HM) ? 4'b0011 : 4'b1100;
        default:     blank_mask = '0;
      endcase
    end
  end

  genvar g;
  generate
    for (g = 0; g < NDIG; g++) begin : g_en
      assign dig_en_no[g] = (idx_q != IDX_W'(g));
    end
  endgenerate

  assign seg_o = blank_mask[idx_q] ? 7'h00 : seg_encode(dig[idx_q]);
  assign dp_o  = (idx_q == IDX_W'(SEP_POS));

endmodule

// File: rtl/tod_split_clock.sv
module tod_split_clock
  import tod_pkg::*;
#(
  parameter int unsigned BLINK_HALF = 250
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sec_tick_i,
  input  logic       scan_tick_i,
  input  logic       view_btn_i,
  input  logic       set_btn_i,
  input  logic       inc_btn_i,
  input  logic       ok_btn_i,
  output logic [6:0] seg_o,
  output logic       dp_o,
  output logic [3:0] dig_en_no
);

  mode_e mode_w;
  view_e view_w;
  logic  enter_edit_w;
  tod_t  tod_w;

  tod_mode_fsm i_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .set_i        (set_btn_i),
    .ok_i         (ok_btn_i),
    .view_btn_i   (view_btn_i),
    .mode_o       (mode_w),
    .view_o       (view_w),
    .enter_edit_o (enter_edit_w)
  );

  tod_counter i_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sec_tick_i (sec_tick_i),
    .clr_sec_i  (enter_edit_w),
    .inc_i      (inc_btn_i),
    .mode_i     (mode_w),
    .tod_o      (tod_w)
  );

  tod_display #(.BLINK_HALF(BLINK_HALF)) i_disp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .scan_tick_i (scan_tick_i),
    .tod_i       (tod_w),
    .mode_i      (mode_w),
    .view_i      (view_w),
    .seg_o       (seg_o),
    .dp_o        (dp_o),
    .dig_en_no   (dig_en_no)
  );

endmodule

// File: rtl/tod_split_clock_chk.sv
module tod_split_clock_chk
  import tod_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scan_tick_i,
  input logic       view_btn_i,
  input logic       set_btn_i,
  input logic       ok_btn_i,
  input logic       dp_o,
  input logic [3:0] dig_en_no,
  input mode_e      mode_i,
  input view_e      view_i,
  input tod_t       tod_i
);

  p_one_digit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~dig_en_no) == 1);

  p_scan_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !scan_tick_i |=> $stable(dig_en_no));

  p_dp_pos_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dp_o == (dig_en_no == 4'b1011));

  p_hours_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tod_i.h_t < 4'd2 && tod_i.h_o <= 4'd9) || (tod_i.h_t == 4'd2 && tod_i.h_o <= 4'd3));

  p_set_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_RUN && set_btn_i) |=> (tod_i.s_t == 4'd0 && tod_i.s_o == 4'd0));

  p_sec_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != MODE_RUN) |=> ($stable(tod_i.s_t) && $stable(tod_i.s_o)));

  p_view_toggle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    view_btn_i |=> (view_i != $past(view_i)));

  p_ok_exit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != MODE_RUN && ok_btn_i) |=> (mode_i == MODE_RUN));

endmodule

bind tod_split_clock tod_split_clock_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .scan_tick_i (scan_tick_i),
  .view_btn_i  (view_btn_i),
  .set_btn_i   (set_btn_i),
  .ok_btn_i    (ok_btn_i),
  .dp_o        (dp_o),
  .dig_en_no   (dig_en_no),
  .mode_i      (mode_w),
  .view_i      (view_w),
  .tod_i       (tod_w)
);

// File: tb/test_tod_split_clock.sv
module test_tod_split_clock;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_t = 0, scan_t = 0, view_b = 0, set_b = 0, inc_b = 0, ok_b = 0;
  logic [6:0] seg;
  logic dp;
  logic [3:0] den_n;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  tod_split_clock #(.BLINK_HALF(HALF)) i_tod_split_clock (
    .clk_i(clk), .rst_ni(rst_n), .sec_tick_i(sec_t), .scan_tick_i(scan_t),
    .view_btn_i(view_b), .set_btn_i(set_b), .inc_btn_i(inc_b), .ok_btn_i(ok_b),
    .seg_o(seg), .dp_o(dp), .dig_en_no(den_n)
  );

  function automatic logic [6:0] enc(input int d);
    case (d)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F; default: return 7'h00;
    endcase
  endfunction

  // behavioural reference: mode 0 run, 1 edit hours, 2 edit minutes
  int hh, mm, ss, md, vw, ix, bc, ph;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hh = 0; mm = 0; ss = 0; md = 0; vw = 0; ix = 0; bc = 0; ph = 0;
    end else begin
      int nmd;
      nmd = md;
      if (md != 0 && ok_b) nmd = 0;
      else if (set_b) nmd = (md + 1) % 3;
      if (md == 0 && set_b) ss = 0;
      else if (md == 0 && sec_t) begin
        ss++;
        if (ss == 60) begin ss = 0; mm++; end
        if (mm == 60) begin mm = 0; hh++; end
        if (hh == 24) hh = 0;
      end else if (md == 1 && inc_b) hh = (hh + 1) % 24;
      else if (md == 2 && inc_b) mm = (mm + 1) % 60;
      md = nmd;
      if (view_b) vw = 1 - vw;
      if (scan_t) begin
        ix = (ix + 1) % 4;
        if (bc == HALF - 1) begin bc = 0; ph = 1 - ph; end else bc++;
      end
    end
  end

  function automatic int exp_digit(input int p);
    int hi, lo;
    hi = (vw == 0) ? hh : mm;
    lo = (vw == 0) ? mm : ss;
    case (p)
      3: return hi / 10; 2: return hi % 10;
      1: return lo / 10; default: return lo % 10;
    endcase
  endfunction

  function automatic bit exp_blank(input int p);
    if (ph == 0) return 0;
    if (md == 1) return (vw == 0) && (p >= 2);
    if (md == 2) return (vw == 0) ? (p < 2) : (p >= 2);
    return 0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, expv, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      logic [6:0] es;
      es = exp_blank(ix) ? 7'h00 : enc(exp_digit(ix));
      chk(den_n == ~(4'b1 << ix), "R9", "dig_en_no", den_n, ~(4'b1 << ix) & 4'hF);
      chk(dp == (ix == 2), "R4", "dp_o", dp, ix == 2);
      chk(seg == es, cur_req, "seg_o", seg, es);
    end
  end

  task automatic cyc(input bit s, input bit sc, input bit v, input bit st, input bit i, input bit o);
    @(negedge clk);
    sec_t = s; scan_t = sc; view_b = v; set_b = st; inc_b = i; ok_b = o;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 0, 0);
  endtask

  function automatic int cur_idx();
    for (int k = 0; k < 4; k++) if (!den_n[k]) return k;
    return 0;
  endfunction

  task automatic read_disp(input int d3, input int d2, input int d1, input int d0, input string req);
    for (int k = 0; k < 4; k++) begin
      int p, e;
      @(negedge clk);
      p = cur_idx();
      e = (p == 3) ? d3 : (p == 2) ? d2 : (p == 1) ? d1 : d0;
      chk(seg == enc(e), req, "readout", seg, enc(e));
      sec_t = 0; scan_t = 1; view_b = 0; set_b = 0; inc_b = 0; ok_b = 0;
    end
    idle(1);
  endtask

  task automatic incs(input int n);
    for (int k = 0; k < n; k++) cyc(0, k[0], 0, 0, 1, 0);
    idle(1);
  endtask

  task automatic secs(input int n);
    for (int k = 0; k < n; k++) cyc(1, k[1], 0, 0, 0, 0);
    idle(1);
  endtask

  task automatic blink_probe(input int pos, input bit expect_blink, input string req);
    int lit, dark;
    lit = 0; dark = 0;
    for (int k = 0; k < 48; k++) begin
      @(negedge clk);
      if (cur_idx() == pos) begin
        if (seg == 7'h00) dark++; else lit++;
      end
      sec_t = 0; scan_t = 1; view_b = 0; set_b = 0; inc_b = 0; ok_b = 0;
    end
    idle(1);
    if (expect_blink) chk(lit > 0 && dark > 0, req, "blink lit/dark seen", dark, 1);
    else chk(dark == 0, req, "no blanking", dark, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(den_n == 4'b1110, "R1", "reset dig_en", den_n, 4'hE);
    chk(seg == 7'h3F, "R1", "reset seg", seg, 7'h3F);
    chk(dp == 1'b0, "R1", "reset dp", dp, 0);
    read_disp(0, 0, 0, 0, "R1");

    // set 23:59 then run into the day wrap
    cur_req = "R7";
    cyc(0, 0, 0, 1, 0, 0); incs(23);
    cyc(0, 0, 0, 1, 0, 0); incs(59);
    cyc(0, 0, 0, 0, 0, 1); idle(1);
    read_disp(2, 3, 5, 9, "R7");
    cur_req = "R2";
    secs(59);
    cyc(0, 0, 1, 0, 0, 0); idle(1);
    read_disp(5, 9, 5, 9, "R3");
    secs(1);
    read_disp(0, 0, 0, 0, "R2");
    cyc(0, 0, 1, 0, 0, 0); idle(1);
    read_disp(0, 0, 0, 0, "R3");

    // increment ignored in run
    cyc(0, 0, 0, 0, 1, 0); idle(1);
    read_disp(0, 0, 0, 0, "R7");

    // 18:46:07 covers the remaining digit codes
    cur_req = "R10";
    cyc(0, 0, 0, 1, 0, 0); incs(18);
    cyc(0, 0, 0, 1, 0, 0); incs(46);
    cyc(0, 0, 0, 0, 0, 1); idle(1);
    secs(7);
    read_disp(1, 8, 4, 6, "R10");
    cyc(0, 0, 1, 0, 0, 0); idle(1);
    read_disp(4, 6, 0, 7, "R10");

    // entering edit clears seconds, ticks then ignored
    cur_req = "R6";
    cyc(0, 0, 0, 1, 0, 0); idle(1);
    secs(5);
    read_disp(4, 6, 0, 0, "R6");
    cyc(0, 0, 0, 0, 0, 1); idle(1);

    // mode sequence and OK priority
    cur_req = "R5";
    cyc(0, 0, 0, 1, 0, 0); cyc(0, 0, 0, 1, 0, 0); cyc(0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 1, 0); idle(1);
    read_disp(4, 6, 0, 0, "R5");
    cyc(0, 0, 0, 1, 0, 1);           // run: ok ignored, enters edit-hours
    cyc(0, 0, 0, 0, 1, 0);           // hours 18 -> 19
    cyc(0, 0, 0, 1, 0, 1);           // ok wins -> run
    cyc(0, 0, 0, 0, 1, 0);           // ignored
    cyc(0, 0, 1, 0, 0, 0); idle(1);
    read_disp(1, 9, 4, 6, "R5");

    // wraps in edit
    cur_req = "R7";
    cyc(0, 0, 0, 1, 0, 0); cyc(0, 0, 0, 1, 0, 0); incs(14);
    cyc(0, 0, 0, 0, 0, 1); idle(1);
    read_disp(1, 9, 0, 0, "R7");
    cyc(0, 0, 0, 1, 0, 0); incs(5);
    cyc(0, 0, 0, 0, 0, 1); idle(1);
    read_disp(0, 0, 0, 0, "R7");

    // blinking
    cur_req = "R8";
    cyc(0, 0, 0, 1, 0, 0); idle(1);            // edit hours, HM view
    blink_probe(3, 1, "R8");
    blink_probe(1, 0, "R8");
    cyc(0, 0, 0, 1, 0, 0); idle(1);            // edit minutes
    blink_probe(0, 1, "R8");
    blink_probe(2, 0, "R8");
    cyc(0, 0, 1, 0, 0, 0); idle(1);            // MS view: minutes on top
    blink_probe(2, 1, "R8");
    cyc(0, 0, 0, 0, 0, 1); idle(1);
    blink_probe(3, 0, "R8");

    // scan holds without a tick
    cur_req = "R9";
    begin
      logic [3:0] held;
      @(negedge clk); held = den_n;
      idle(8);
      chk(den_n == held, "R9", "scan hold", den_n, held);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule